// File: doc/BRIEF.md
# UART Interrupt Hub

This block gathers the interrupt causes of a serial-port peripheral into two levels and drives one active-low interrupt request. Frequent causes (top-level event pulses from the transmit and receive paths) are latched straight into a summary register that software reads first. Rare causes are held in three detail registers: line conditions, general status events and special-character matches. Three low-order bits of the summary register point at whichever detail register currently holds an enabled cause.

Each of the four cause registers has a matching read/write enable register of the same width. Software reads and writes through a plain register bus: a 3-bit address, a read strobe that returns data in the same cycle, and a write strobe with 8-bit data. There is no streaming data path, so the bus has no valid/ready handshake; a strobe is accepted in every cycle it is high. The summary, general and special-character registers are cleared by reading them, while the line register mirrors its live condition and is not changed by reads.

Address decode: 0 summary, 1 line, 2 general, 3 special-character, 4 summary enable, 5 line enable, 6 general enable, 7 special-character enable.

Top module: `uart_irq_hub`

## Requirements
- R1: After reset every cause and enable register reads 0 and `irq_n` is 1.
- R2: A pulse on `top_evt[k]` sets summary bit k+3, which stays set until the summary register is read.
- R3: Summary bits 0, 1 and 2 read as the OR of (line & line enable), (general & general enable) and (special & special enable) respectively, updated in the same cycle as those registers.
- R4: `irq_n` is 0 exactly when the summary value ANDed with the summary enable register is nonzero.
- R5: A read of address 0 returns the current summary value and clears summary bits 7..3 at the following clock edge.
- R6: Pulses on `gen_evt` and `char_evt` set bits in the general (address 2) and special (address 3) registers; a read returns the contents and clears them at the following edge.
- R7: The line register (address 1) equals `line_cond` as sampled at the previous clock edge; reading it does not change it.
- R8: A cause pulse arriving in the same cycle as a clearing read of its register leaves that bit set after the read.
- R9: Writes to addresses 4..7 load the enable registers, which read back the written value.
- R10: Writes to addresses 0..3 have no effect on any register.
- R11: `rd_data` is 0 in every cycle in which `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_evt | input | 5 | Frequent cause pulses, summary bits 7..3 |
| line_cond | input | 8 | Live line conditions (levels) |
| gen_evt | input | 8 | General status cause pulses |
| char_evt | input | 8 | Special-character match pulses |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the cycle of `rd_en` |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Because `irq_n` and the pointer bits are combinational from the stored registers, a wrong stored bit or enable shows on `irq_n` in the very cycle after the faulty edge whenever that bit is enabled, and on `rd_data` at the next read of the affected address. A clearing rule applied to the wrong register shows as a line bit vanishing after a read, or a general bit surviving one, at the second read. Event-versus-read collisions and writes aimed at cause registers are driven on purpose so that a lost or spurious bit is visible within two cycles.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_W  = 8;
  localparam int PTR_N  = 3;
  localparam int ADDR_W = 3;
  localparam int BANK_N = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TOP     = 3'd0,
    SEL_LINE    = 3'd1,
    SEL_GEN     = 3'd2,
    SEL_CHAR    = 3'd3,
    SEL_EN_TOP  = 3'd4,
    SEL_EN_LINE = 3'd5,
    SEL_EN_GEN  = 3'd6,
    SEL_EN_CHAR = 3'd7
  } reg_sel_e;

  typedef enum logic {
    CLR_ON_READ,
    CLR_ON_SOURCE
  } clr_mode_e;
endpackage

// File: rtl/irq_src_reg.sv
module irq_src_reg
  import uart_irq_pkg::*;
#(
  parameter int        W    = 8,
  parameter clr_mode_e MODE = CLR_ON_READ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         rd_hit,
  output logic [W-1:0] q
);
  generate
    if (MODE == CLR_ON_READ) begin : g_cor
      // new cause pulses win over a clearing read
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= src | (rd_hit ? '0 : q);
      end
    end else begin : g_follow
      logic unused_rd;
      assign unused_rd = rd_hit;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= src;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int W = 8,
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [W-1:0]        wr_data,
  output logic [N-1:0][W-1:0] en
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           r <= '0;
      else if (wr_en && wr_idx == IW'(i))   r <= wr_data;
    end
    assign en[i] = r;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int W     = 8,
  parameter int PTR_N = 3
) (
  input  logic [W-PTR_N-1:0] top_lat,
  input  logic [W-1:0]       line_q,
  input  logic [W-1:0]       gen_q,
  input  logic [W-1:0]       char_q,
  input  logic [W-1:0]       en_top,
  input  logic [W-1:0]       en_line,
  input  logic [W-1:0]       en_gen,
  input  logic [W-1:0]       en_char,
  output logic [W-1:0]       top_val,
  output logic               irq_n
);
  logic [PTR_N-1:0] ptr;

  // pointer bits are live, so they inherit each detail register's clearing rule
  assign ptr[0] = |(line_q & en_line);
  assign ptr[1] = |(gen_q  & en_gen);
  assign ptr[2] = |(char_q & en_char);

  assign top_val = {top_lat, ptr};
  assign irq_n   = ~|(top_val & en_top);
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
  import uart_irq_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW-PTR_N-1:0] top_evt,
  input  logic [DW-1:0]       line_cond,
  input  logic [DW-1:0]       gen_evt,
  input  logic [DW-1:0]       char_evt,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_data,
  output logic                irq_n
);
  localparam int TOP_N = DW - PTR_N;

  logic [TOP_N-1:0]         top_lat;
  logic [DW-1:0]            line_q, gen_q, char_q, top_val;
  logic [BANK_N-1:0][DW-1:0] en;
  logic [DW-1:0]            en_top, en_line, en_gen, en_char;
  reg_sel_e                 sel;

  assign sel     = reg_sel_e'(addr);
  assign en_top  = en[0];
  assign en_line = en[1];
  assign en_gen  = en[2];
  assign en_char = en[3];

  irq_src_reg #(.W(TOP_N), .MODE(CLR_ON_READ)) u_top (
    .clk(clk), .rst_n(rst_n), .src(top_evt),
    .rd_hit(rd_en && sel == SEL_TOP), .q(top_lat));

  irq_src_reg #(.W(DW), .MODE(CLR_ON_SOURCE)) u_line (
    .clk(clk), .rst_n(rst_n), .src(line_cond),
    .rd_hit(rd_en && sel == SEL_LINE), .q(line_q));

  irq_src_reg #(.W(DW), .MODE(CLR_ON_READ)) u_gen (
    .clk(clk), .rst_n(rst_n), .src(gen_evt),
    .rd_hit(rd_en && sel == SEL_GEN), .q(gen_q));

  irq_src_reg #(.W(DW), .MODE(CLR_ON_READ)) u_char (
    .clk(clk), .rst_n(rst_n), .src(char_evt),
    .rd_hit(rd_en && sel == SEL_CHAR), .q(char_q));

  // address MSB selects the enable bank; cause registers ignore writes
  irq_en_bank #(.W(DW), .N(BANK_N)) u_en (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && addr[ADDR_W-1]),
    .wr_idx(addr[ADDR_W-2:0]),
    .wr_data(wr_data), .en(en));

  irq_summary #(.W(DW), .PTR_N(PTR_N)) u_sum (
    .top_lat(top_lat), .line_q(line_q), .gen_q(gen_q), .char_q(char_q),
    .en_top(en_top), .en_line(en_line), .en_gen(en_gen), .en_char(en_char),
    .top_val(top_val), .irq_n(irq_n));

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_TOP:     rd_data = top_val;
        SEL_LINE:    rd_data = line_q;
        SEL_GEN:     rd_data = gen_q;
        SEL_CHAR:    rd_data = char_q;
        SEL_EN_TOP:  rd_data = en_top;
        SEL_EN_LINE: rd_data = en_line;
        SEL_EN_GEN:  rd_data = en_gen;
        SEL_EN_CHAR: rd_data = en_char;
        default:     rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_hub_chk.sv
module uart_irq_hub_chk
  import uart_irq_pkg::*;
#(
  parameter int DW = REG_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DW-PTR_N-1:0] top_evt,
  input logic [DW-1:0]       line_cond,
  input logic [DW-1:0]       gen_evt,
  input logic [DW-1:0]       char_evt,
  input logic [ADDR_W-1:0]   addr,
  input logic                rd_en,
  input logic                wr_en,
  input logic [DW-1:0]       wr_data,
  input logic [DW-1:0]       rd_data,
  input logic                irq_n,
  input logic [DW-PTR_N-1:0] top_lat,
  input logic [DW-1:0]       line_q,
  input logic [DW-1:0]       gen_q,
  input logic [DW-1:0]       char_q,
  input logic [DW-1:0]       en_top
);
  p_top_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (top_evt == '0 && !(rd_en && addr == SEL_TOP)) |=> $stable(top_lat));

  p_irq_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_TOP && !wr_en && top_evt == '0 && en_top[PTR_N-1:0] == '0)
      |=> irq_n);

  p_top_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_TOP) |=> top_lat == $past(top_evt));

  p_gen_cor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_GEN) |=> gen_q == $past(gen_evt));

  p_char_cor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == SEL_CHAR) |=> char_q == $past(char_evt));

  p_line_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> line_q == $past(line_cond));

  p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SEL_EN_TOP) |=> en_top == $past(wr_data));

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
endmodule

bind uart_irq_hub uart_irq_hub_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .top_evt(top_evt), .line_cond(line_cond),
  .gen_evt(gen_evt), .char_evt(char_evt), .addr(addr), .rd_en(rd_en),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n),
  .top_lat(top_lat), .line_q(line_q), .gen_q(gen_q), .char_q(char_q),
  .en_top(en_top));

// File: tb/sim_uart_irq_hub.sv
`timescale 1ns/1ps
module sim_uart_irq_hub;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] top_evt = '0;
  logic [7:0] line_cond = '0, gen_evt = '0, char_evt = '0;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [4:0] m_top;
  logic [7:0] m_line, m_gen, m_char;
  logic [7:0] m_en [4];

  always #4 clk = ~clk;

  uart_irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .top_evt(top_evt), .line_cond(line_cond),
    .gen_evt(gen_evt), .char_evt(char_evt), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n));

  function automatic logic [7:0] m_topval();
    logic [2:0] p;
    p[0] = |(m_line & m_en[1]);
    p[1] = |(m_gen  & m_en[2]);
    p[2] = |(m_char & m_en[3]);
    return {m_top, p};
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_topval();
      3'd1: return m_line;
      3'd2: return m_gen;
      3'd3: return m_char;
      default: return m_en[a - 3'd4];
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd1: return "R7";
      3'd2, 3'd3: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive after negedge, check before posedge, update model at posedge
  task automatic step(input logic [4:0] te, input logic [7:0] lc, input logic [7:0] ge,
                      input logic [7:0] ce, input bit rd, input bit wr,
                      input logic [2:0] a, input logic [7:0] wd, input string tag);
    string t;
    @(negedge clk);
    top_evt = te; line_cond = lc; gen_evt = ge; char_evt = ce;
    rd_en = rd; wr_en = wr; addr = a; wr_data = wd;
    #1;
    if (rd) begin
      t = (tag == "") ? tag_for(a) : tag;
      chk(rd_data === m_read(a), t, rd_data, m_read(a));
    end else begin
      chk(rd_data === 8'h00, "R11", rd_data, 8'h00);
    end
    chk(irq_n === ~|(m_topval() & m_en[0]), (tag == "") ? "R4" : tag,
        {7'd0, irq_n}, {7'd0, ~|(m_topval() & m_en[0])});
    @(posedge clk);
    m_top  = te | ((rd && a == 3'd0) ? 5'd0 : m_top);
    m_gen  = ge | ((rd && a == 3'd2) ? 8'd0 : m_gen);
    m_char = ce | ((rd && a == 3'd3) ? 8'd0 : m_char);
    m_line = lc;
    if (wr && a[2]) m_en[a[1:0]] = wd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_top = '0; m_line = '0; m_gen = '0; m_char = '0;
    for (int i = 0; i < 4; i++) m_en[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values of every register
    for (int a = 0; a < 8; a++) step('0, '0, '0, '0, 1, 0, 3'(a), '0, "R1");

    // R2: frequent causes latch into bits 7..3 and stay until read
    step(5'b10101, '0, '0, '0, 0, 0, 3'd0, '0, "R2");
    step('0, '0, '0, '0, 1, 0, 3'd0, '0, "R2");
    step('0, '0, '0, '0, 1, 0, 3'd0, '0, "R5");

    // R3/R4: pointer bits follow enabled detail bits; irq follows summary enable
    step('0, '0, '0, '0, 0, 1, 3'd6, 8'h04, "R9");
    step('0, '0, '0, '0, 0, 1, 3'd4, 8'h02, "R9");
    step('0, '0, 8'h01, '0, 1, 0, 3'd0, '0, "R3");
    step('0, '0, 8'h04, '0, 1, 0, 3'd0, '0, "R3");
    step('0, '0, '0, '0, 0, 0, 3'd0, '0, "R4");
    step('0, '0, '0, '0, 1, 0, 3'd2, '0, "R6");
    step('0, '0, '0, '0, 0, 0, 3'd0, '0, "R4");

    // R8: cause arrives in the same cycle as its clearing read
    step('0, '0, '0, 8'h40, 0, 0, 3'd0, '0, "R6");
    step('0, '0, '0, 8'h40, 1, 0, 3'd3, '0, "R8");
    step('0, '0, '0, '0, 1, 0, 3'd3, '0, "R8");
    step(5'b00010, '0, '0, '0, 1, 0, 3'd0, '0, "R8");
    step('0, '0, '0, '0, 1, 0, 3'd0, '0, "R8");

    // R7: line register mirrors its condition and survives reads
    step('0, 8'h81, '0, '0, 0, 1, 3'd5, 8'hFF, "R9");
    step('0, 8'h81, '0, '0, 1, 0, 3'd1, '0, "R7");
    step('0, 8'h81, '0, '0, 1, 0, 3'd1, '0, "R7");
    step('0, 8'h00, '0, '0, 1, 0, 3'd1, '0, "R7");
    step('0, 8'h00, '0, '0, 1, 0, 3'd1, '0, "R7");

    // R10: writes aimed at cause registers change nothing
    for (int a = 0; a < 4; a++) step('0, '0, '0, '0, 0, 1, 3'(a), 8'hFF, "R10");
    for (int a = 0; a < 4; a++) step('0, '0, '0, '0, 1, 0, 3'(a), '0, "R10");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] te;
      logic [7:0] lc, ge, ce, wd;
      logic [2:0] a;
      bit rd, wr;
      te = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      lc = ($urandom % 8 == 0) ? 8'($urandom) : m_line;
      ge = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      ce = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      a  = 3'($urandom);
      wd = 8'($urandom);
      rd = ($urandom % 2) == 0;
      wr = ($urandom % 5) == 0;
      step(te, lc, ge, ce, rd, wr, a, wd, "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule